// File: doc/BRIEF.md
# Iterative Feistel Round Engine

This block runs a 64-bit Feistel cipher one round per clock. A start pulse captures the input block and a direction bit. The block splits the input into a left half and a right half and holds both in a state register. In every round it sends the right half and that round's 60-bit subkey out through a round-function port. It takes a 32-bit result back on the same cycle. That result is XORed into the left half, and then the two halves trade places. The final round keeps the halves where they are.

The sixteen round subkeys sit in a local store. The store is filled through a simple write port while the engine is idle. Encryption reads the store from entry 0 upward. Decryption uses the same datapath and reads the store from entry 15 downward. The round function and the expansion of a user key into subkeys are outside this block and are supplied by the surrounding logic.

Top module: `feistel_iter_core`

## Requirements
- R1: After reset, `busy` and `done` are low and `dout` is all zeros.
- R2: A `start` pulse while idle captures `din` and `decrypt`. `busy` is high from the next cycle, and in that first busy cycle `f_arg` equals `din[31:0]`.
- R3: In round k of an encryption, counting from 0, `f_arg` shows the current right half and `f_key` shows store entry k, both in the same cycle.
- R4: In round k of a decryption, `f_key` shows store entry 15-k.
- R5: Each round replaces the left half with left XOR `f_res` and then swaps the halves. Round 15 does no swap. `dout` is {left, right}, with left in bits 63:32.
- R6: `done` is high for exactly one cycle, 16 cycles after the accepting `start` edge. `busy` falls on that same edge.
- R7: While idle and with no `start`, `dout` keeps its value.
- R8: A `start` while `busy` is high is ignored. The block in progress finishes with its own data and direction.
- R9: A subkey write while `busy` is high leaves the store unchanged. A write while idle stores `kwr_data` at entry `kwr_addr`.
- R10: Decrypting a ciphertext with the same subkeys returns the original block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block (used only when idle) |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt; captured with `start` |
| din | input | 64 | Input block, left half in bits 63:32 |
| kwr_en | input | 1 | Subkey store write enable |
| kwr_addr | input | 4 | Subkey store entry to write |
| kwr_data | input | 60 | Subkey value to write |
| f_arg | output | 32 | Right half sent to the round function |
| f_key | output | 60 | Subkey for the current round |
| f_res | input | 32 | Round-function result for the current round |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse: `dout` is valid |
| dout | output | 64 | Output block, left half in bits 63:32 |

## Verification
The bench first checks the subkey order of every round in both directions. An engine that indexed the store the wrong way would present a wrong `f_key` in some round and break the decrypt round trip. It then checks the missing swap in the last round against its own arithmetic model. A design that swapped there would produce outputs with the halves exchanged. The bench also fires a stray `start` and a stray subkey write in the middle of a block. A design that honoured the `start` would return the wrong result. A design that honoured the write would make the next block differ from the model. Finally, the bench times the `done` pulse exactly and watches `dout` during idle cycles, to catch a late, long or repeated pulse and any drift of the output.

// File: rtl/feistel_pkg.sv
package feistel_pkg;
   typedef enum logic {
      DIR_ENC = 1'b0,
      DIR_DEC = 1'b1
   } fk_dir_e;
endpackage

// File: rtl/fk_subkey_store.sv
module fk_subkey_store #(
   parameter int DEPTH = 16,
   parameter int KEY_W = 60,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [AW-1:0]               waddr,
   input  logic [KEY_W-1:0]            wdata,
   input  logic [AW-1:0]               raddr,
   output logic [KEY_W-1:0]            rdata,
   output logic [DEPTH-1:0][KEY_W-1:0] mem_q
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           mem_q[e] <= '0;
         else if (we && waddr == AW'(e))       mem_q[e] <= wdata;
      end
   end

   // Combinational read: the subkey is ready in the same cycle as its round.
   assign rdata = mem_q[raddr];
endmodule

// File: rtl/fk_round_seq.sv
module fk_round_seq
   import feistel_pkg::*;
#(
   parameter int ROUNDS = 16,
   localparam int CW    = $clog2(ROUNDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  fk_dir_e       dir_in,
   output logic          accept,
   output logic          busy,
   output logic          done,
   output logic          last,
   output fk_dir_e       dir_q,
   output logic [CW-1:0] key_idx
);
   logic [CW-1:0] round_q;

   assign accept = start && !busy;
   assign last   = busy && (round_q == CW'(ROUNDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         round_q <= '0;
         dir_q   <= DIR_ENC;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            round_q <= '0;
            dir_q   <= dir_in;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            round_q <= round_q + 1'b1;
         end
      end
   end

   assign key_idx = (dir_q == DIR_DEC) ? (CW'(ROUNDS - 1) - round_q) : round_q;
endmodule

// File: rtl/fk_half_state.sv
module fk_half_state #(
   parameter int HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [2*HALF_W-1:0] blk_in,
   input  logic                step,
   input  logic                last,
   input  logic [HALF_W-1:0]   f_res,
   output logic [HALF_W-1:0]   left_q,
   output logic [HALF_W-1:0]   right_q
);
   logic [HALF_W-1:0] mixed;
   assign mixed = left_q ^ f_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         right_q <= '0;
      end else if (load) begin
         left_q  <= blk_in[2*HALF_W-1:HALF_W];
         right_q <= blk_in[HALF_W-1:0];
      end else if (step) begin
         if (last) begin
            left_q <= mixed;
         end else begin
            left_q  <= right_q;
            right_q <= mixed;
         end
      end
   end
endmodule

// File: rtl/feistel_iter_core.sv
module feistel_iter_core
   import feistel_pkg::*;
#(
   parameter int BLOCK_W = 64,
   parameter int KEY_W   = 60,
   parameter int ROUNDS  = 16,
   localparam int HALF_W = BLOCK_W / 2,
   localparam int AW     = $clog2(ROUNDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               decrypt,
   input  logic [BLOCK_W-1:0] din,
   input  logic               kwr_en,
   input  logic [AW-1:0]      kwr_addr,
   input  logic [KEY_W-1:0]   kwr_data,
   output logic [HALF_W-1:0]  f_arg,
   output logic [KEY_W-1:0]   f_key,
   input  logic [HALF_W-1:0]  f_res,
   output logic               busy,
   output logic               done,
   output logic [BLOCK_W-1:0] dout
);
   if (BLOCK_W % 2 != 0) begin : g_bad_block
      $error("BLOCK_W must be even");
   end
   if (ROUNDS < 2) begin : g_bad_rounds
      $error("ROUNDS must be at least 2");
   end
   if (KEY_W < 1) begin : g_bad_key
      $error("KEY_W must be positive");
   end

   logic                        accept, last;
   fk_dir_e                     dir_q;
   logic [AW-1:0]               key_idx;
   logic [HALF_W-1:0]           left_q, right_q;
   logic [ROUNDS-1:0][KEY_W-1:0] key_mem;

   fk_round_seq #(.ROUNDS(ROUNDS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dir_in(decrypt ? DIR_DEC : DIR_ENC),
      .accept(accept), .busy(busy), .done(done), .last(last),
      .dir_q(dir_q), .key_idx(key_idx)
   );

   fk_subkey_store #(.DEPTH(ROUNDS), .KEY_W(KEY_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(kwr_en && !busy), .waddr(kwr_addr), .wdata(kwr_data),
      .raddr(key_idx), .rdata(f_key), .mem_q(key_mem)
   );

   fk_half_state #(.HALF_W(HALF_W)) u_state (
      .clk(clk), .rst_n(rst_n), .load(accept), .blk_in(din),
      .step(busy), .last(last), .f_res(f_res),
      .left_q(left_q), .right_q(right_q)
   );

   assign f_arg = right_q;
   assign dout  = {left_q, right_q};
endmodule

// File: rtl/fk_checker.sv
module fk_checker #(
   parameter int BLOCK_W = 64,
   parameter int KEY_W   = 60,
   parameter int ROUNDS  = 16,
   localparam int CW     = $clog2(ROUNDS) + 1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start,
   input logic                         busy,
   input logic                         done,
   input logic [BLOCK_W-1:0]           dout,
   input logic                         dir_q,
   input logic [ROUNDS-1:0][KEY_W-1:0] key_mem
);
   logic [CW-1:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy_cnt <= '0;
      else if (start && !busy)   busy_cnt <= '0;
      else if (busy)             busy_cnt <= busy_cnt + 1'b1;
   end

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy_cnt == CW'(ROUNDS));
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(dout));
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(dir_q));
   p_keys_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(key_mem));
endmodule

bind feistel_iter_core fk_checker #(
   .BLOCK_W(BLOCK_W), .KEY_W(KEY_W), .ROUNDS(ROUNDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .dout(dout), .dir_q(u_seq.dir_q), .key_mem(u_store.mem_q)
);

// File: tb/feistel_iter_core_tb.sv
module feistel_iter_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, decrypt = 1'b0;
   logic [63:0] din = '0;
   logic        kwr_en = 1'b0;
   logic [3:0]  kwr_addr = '0;
   logic [59:0] kwr_data = '0;
   logic [31:0] f_arg, f_res;
   logic [59:0] f_key;
   logic        busy, done;
   logic [63:0] dout;

   int checks = 0, failures = 0;
   bit finished = 0;
   logic [59:0] keys [16];

   always #4 clk = ~clk;

   feistel_iter_core u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt), .din(din),
      .kwr_en(kwr_en), .kwr_addr(kwr_addr), .kwr_data(kwr_data),
      .f_arg(f_arg), .f_key(f_key), .f_res(f_res),
      .busy(busy), .done(done), .dout(dout)
   );

   function automatic logic [31:0] rf(input logic [31:0] x, input logic [59:0] k);
      logic [31:0] t;
      t = (x ^ k[31:0]) + {x[20:0], x[31:21]};
      return t ^ {4'h0, k[59:32]} ^ (t >> 7);
   endfunction

   assign f_res = rf(f_arg, f_key);

   function automatic logic [63:0] model(input logic [63:0] blk, input bit dec);
      logic [31:0] l, r, t;
      l = blk[63:32];
      r = blk[31:0];
      for (int k = 0; k < 16; k++) begin
         t = l ^ rf(r, dec ? keys[15-k] : keys[k]);
         if (k < 15) begin
            l = r;
            r = t;
         end else begin
            l = t;
         end
      end
      return {l, r};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_key(input int a, input logic [59:0] v);
      @(negedge clk);
      kwr_en = 1'b1; kwr_addr = 4'(a); kwr_data = v;
      @(negedge clk);
      kwr_en = 1'b0;
   endtask

   // Runs one block; optionally injects a stray start (R8) or key write (R9) mid-block.
   task automatic run_block(input logic [63:0] blk, input bit dec,
                            input bit stray_start, input bit stray_write,
                            output logic [63:0] res);
      logic [63:0] exp;
      exp = model(blk, dec);
      @(negedge clk);
      start = 1'b1; din = blk; decrypt = dec;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R2 busy after start", {63'b0, busy}, 64'd1);
      check(f_arg === blk[31:0], "R2 first f_arg", {32'b0, f_arg}, {32'b0, blk[31:0]});
      for (int k = 0; k < 16; k++) begin
         if (dec) check(f_key === keys[15-k], "R4 reverse subkey", {4'b0, f_key}, {4'b0, keys[15-k]});
         else     check(f_key === keys[k], "R3 forward subkey", {4'b0, f_key}, {4'b0, keys[k]});
         check(done === 1'b0, "R6 no early done", {63'b0, done}, 64'd0);
         if (stray_start && k == 5) begin
            start = 1'b1; din = ~blk; decrypt = ~dec;
         end else if (stray_write && k == 7) begin
            kwr_en = 1'b1; kwr_addr = 4'd3; kwr_data = ~keys[3];
         end else begin
            start = 1'b0; kwr_en = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0; kwr_en = 1'b0;
      check(done === 1'b1 && busy === 1'b0, "R6 done at round 16", {62'b0, done, busy}, 64'd2);
      check(dout === exp, stray_start ? "R8 stray start ignored" : "R5 round result", dout, exp);
      res = dout;
      @(negedge clk);
      check(done === 1'b0, "R6 single cycle done", {63'b0, done}, 64'd0);
      repeat (3) @(negedge clk);
      check(dout === res, "R7 output held", dout, res);
   endtask

   initial begin
      logic [63:0] ct, pt, blk;
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {62'b0, busy, done}, 64'd0);
      check(dout === 64'd0, "R1 reset dout", dout, 64'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         keys[i] = {4'(i), 28'(i * 32'h0137_9BDF), 28'(32'h0A5C_3E71 ^ (i * 32'h0111_1111))};
         write_key(i, keys[i]);
      end
      // R9: an idle write lands; confirmed by forward key check in the next run
      foreach (keys[i]) ;
      run_block(64'd0, 1'b0, 0, 0, ct);
      run_block(ct, 1'b1, 0, 0, pt);
      check(pt === 64'd0, "R10 round trip zero", pt, 64'd0);
      run_block(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, 0, ct);
      run_block(64'h0123_4567_89AB_CDEF, 1'b0, 0, 0, ct);
      run_block(ct, 1'b1, 0, 0, pt);
      check(pt === 64'h0123_4567_89AB_CDEF, "R10 round trip pattern", pt, 64'h0123_4567_89AB_CDEF);
      run_block(64'hAAAA_5555_0F0F_F0F0, 1'b1, 0, 0, ct);
      // R8: a stray start mid-block must not disturb the block in flight
      run_block(64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1, 0, ct);
      // R9: a stray write mid-block must leave the keys alone; the model uses unchanged keys
      run_block(64'h1357_9BDF_2468_ACE0, 1'b0, 0, 1, ct);
      run_block(64'h1357_9BDF_2468_ACE0, 1'b1, 0, 0, ct);
      // R9: idle write takes effect
      keys[9] = 60'hF0F_0F0F_0F0F_0F0F;
      write_key(9, keys[9]);
      blk = 64'h0;
      for (int n = 0; n < 20; n++) begin
         blk = {blk[62:0], blk[63] ^ blk[62] ^ blk[60] ^ blk[59]} ^ 64'(n * 64'h9E37_79B9_7F4A_7C15);
         run_block(blk, 1'b0, 0, 0, ct);
         run_block(ct, 1'b1, 0, 0, pt);
         check(pt === blk, "R10 sweep round trip", pt, blk);
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule